// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Static-Memory Line Refill

This block sits between a 32-bit CPU read port and an external static memory with a narrow data bus (16 bits by default, 8 bits as a build option). It keeps a direct-mapped store of 256 lines of four 32-bit words. For each line it holds a tag and a valid bit. A read that hits returns its word in the same cycle without stalling. A read that misses holds the CPU stalled while the whole line is fetched from the static memory, one narrow access after another at consecutive memory addresses.

Each access holds its address and output enable for a number of wait states. That number comes from a fixed decode of the address: bit 31 selects the slow region. An optional extra cycle after each access keeps the address stable past the point where read data is captured, which protects hold time. Narrow reads are packed into 32-bit words with the first one read in the most significant position.

After reset, a pass visits every line and clears its valid bit before the first lookup is served. The tag leaves out address bits 26:21 on purpose. Addresses that differ only in those bits therefore share one cache entry and return the same data.

Top module: `cache_refill`

## Requirements
- R1: Address bits 11:4 select one of 256 lines and bits 3:2 select the word within the line. A read that hits drives that word on `cpu_data` with `cpu_stall` low in the same cycle. This holds for the first and the last line index.
- R2: The tag is address bits 31:27 together with 20:12. A read whose address differs from a cached one only in bits 26:21 hits and returns the cached data.
- R3: After reset, a sweep of 256 cycles clears every valid bit. During the sweep `cpu_stall` is high and no refill starts. A line filled before a reset misses after it.
- R4: A miss raises `cpu_stall` in the cycle of the request and keeps it high until the word is valid. The refill reads the whole line in order, starting at the line base, with the memory address rising by one per access. It uses 8 accesses for a 16-bit bus.
- R5: Words are packed big-endian. The narrow read at the lower memory address lands in bits 31:16 (16-bit bus).
- R6: Each access lasts 1 + WS + HOLD cycles. WS is `WS_LO` when address bit 31 is 0 and `WS_HI` when it is 1. A miss therefore stalls for 1 + accesses × (1 + WS + HOLD) sampled cycles.
- R7: With `HOLD` = 1, each access keeps its address and output enable for one cycle after the data capture. With `HOLD` = 0, it does not.
- R8: With `SRAM_W` = 8, a word is four byte reads. The byte at the lowest address goes to bits 31:24. A line takes 16 accesses and the memory address gains one bit.
- R9: A miss on a line already holding another tag replaces that line. The previous address then misses again.
- R10: `sram_oe_n` is low only during refill accesses, and is high in reset, during the sweep and while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_rd | input | 1 | Read request, held with a stable address while stalled |
| cpu_addr | input | 32 | Byte address of the read |
| cpu_stall | output | 1 | High while the requested word is not available |
| cpu_data | output | 32 | Read word |
| sram_addr | output | SA_W | Static memory address, in units of the bus width |
| sram_oe_n | output | 1 | Static memory output enable, active low |
| sram_data | input | SRAM_W | Static memory read data |

## Verification
The assertions watch the refill on every cycle. They check that the memory address holds steady for the whole of each access, and that it moves up by exactly one between accesses. They also check that the output enable is never active while the CPU is free to run, that no refill starts straight out of the sweep, and that the word hits as soon as its refill ends. The bench scenarios are needed for the rest. Only they can show that tag aliasing over bits 26:21 returns old data, that eviction occurs, that the halves or bytes come out in the right order, that the stall is exactly as long as the wait states require in each region, and that a reset really clears lines filled earlier.

// File: rtl/cache_refill.sv
module cache_refill #(
  parameter int SRAM_W = 16,
  parameter int SA_W   = 24,
  parameter int WS_LO  = 1,
  parameter int WS_HI  = 2,
  parameter int HOLD   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic [31:0]       cpu_addr,
  output logic              cpu_stall,
  output logic [31:0]       cpu_data,
  output logic [SA_W-1:0]   sram_addr,
  output logic              sram_oe_n,
  input  logic [SRAM_W-1:0] sram_data
);
  localparam int PARTS = 32 / SRAM_W;
  localparam int PB    = $clog2(PARTS);
  localparam int SB    = $clog2(SRAM_W / 8);
  localparam int AB    = 2 + PB;

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_FILL} state_t;
  state_t state;

  logic [7:0]    icnt;
  logic [AB-1:0] acc;
  logic [7:0]    cnt;
  logic [31:0]   wbuf;

  logic [31:0] dmem  [1024];
  logic [13:0] tmem  [256];
  logic [255:0] valid;

  wire [7:0]  idx  = cpu_addr[11:4];
  wire [1:0]  wsel = cpu_addr[3:2];
  wire [13:0] tag  = {cpu_addr[31:27], cpu_addr[20:12]};
  wire [7:0]  ws   = cpu_addr[31] ? 8'(WS_HI) : 8'(WS_LO);
  wire [7:0]  last = ws + 8'(HOLD);

  wire hit      = (state == S_IDLE) && valid[idx] && (tmem[idx] == tag);
  wire capture  = (state == S_FILL) && (cnt == ws);
  wire step     = (state == S_FILL) && (cnt == last);
  wire fill_end = step && (acc == '1);

  assign cpu_stall = (state != S_IDLE) || (cpu_rd && !hit);
  assign cpu_data  = dmem[{idx, wsel}];
  assign sram_addr = {cpu_addr[SA_W+SB-1:AB+SB], acc};
  assign sram_oe_n = (state != S_FILL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_INIT;
      icnt  <= '0;
      acc   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_INIT: begin
          icnt <= icnt + 8'd1;
          if (icnt == 8'hFF) state <= S_IDLE;
        end
        S_IDLE: begin
          if (cpu_rd && !hit) begin
            state <= S_FILL;
            acc   <= '0;
            cnt   <= '0;
          end
        end
        default: begin
          if (step) begin
            cnt <= '0;
            if (acc == '1) state <= S_IDLE;
            else acc <= acc + 1'b1;
          end else begin
            cnt <= cnt + 8'd1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (capture) wbuf <= {wbuf[31-SRAM_W:0], sram_data};
  end

  always_ff @(posedge clk) begin
    if (capture && acc[PB-1:0] == '1)
      dmem[{idx, acc[AB-1:PB]}] <= {wbuf[31-SRAM_W:0], sram_data};
    if (state == S_INIT)
      valid[icnt] <= 1'b0;
    else if (fill_end) begin
      valid[idx] <= 1'b1;
      tmem[idx]  <= tag;
    end
  end

  p_oe_only_stalled_r10: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> cpu_stall);

  p_addr_held_in_access_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_FILL && cnt != 8'd0) |-> ($stable(sram_addr) && !sram_oe_n));

  p_addr_steps_by_one_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_FILL && $past(state) == S_FILL && cnt == 8'd0 && $stable(cpu_addr))
      |-> (sram_addr == SA_W'($past(sram_addr) + 1'b1)));

  p_hit_after_fill_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_FILL && state == S_IDLE && cpu_rd && $stable(cpu_addr))
      |-> !cpu_stall);

  p_no_fill_from_sweep_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_INIT) |-> (state != S_FILL));
endmodule

// File: tb/cache_refill_test.sv
`timescale 1ns/1ps
module cache_refill_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        rd, rd8;
  logic [31:0] addr, addr8, data, data8;
  logic        stall, stall8, oe_n, oe_n8;
  logic [23:0] sa, sa8;
  logic [15:0] sd;
  logic [7:0]  sd8;

  function automatic logic [15:0] f16(input logic [23:0] h);
    return h[15:0] ^ {h[23:16], h[23:16]} ^ 16'h3C5A;
  endfunction
  function automatic logic [7:0] f8(input logic [23:0] b);
    return b[7:0] ^ b[15:8] ^ b[23:16] ^ 8'h96;
  endfunction
  function automatic logic [31:0] exp16(input logic [31:0] a);
    logic [23:0] h;
    h = {a[24:2], 1'b0};
    return {f16(h), f16(h | 24'd1)};
  endfunction
  function automatic logic [31:0] exp8(input logic [31:0] a);
    logic [23:0] b;
    b = {a[23:2], 2'b00};
    return {f8(b), f8(b + 24'd1), f8(b + 24'd2), f8(b + 24'd3)};
  endfunction

  assign sd  = f16(sa);
  assign sd8 = f8(sa8);

  cache_refill #(.SRAM_W(16), .SA_W(24), .WS_LO(1), .WS_HI(2), .HOLD(1)) uut (
    .clk(clk), .rst(rst), .cpu_rd(rd), .cpu_addr(addr), .cpu_stall(stall),
    .cpu_data(data), .sram_addr(sa), .sram_oe_n(oe_n), .sram_data(sd));

  cache_refill #(.SRAM_W(8), .SA_W(24), .WS_LO(0), .WS_HI(0), .HOLD(0)) uut8 (
    .clk(clk), .rst(rst), .cpu_rd(rd8), .cpu_addr(addr8), .cpu_stall(stall8),
    .cpu_data(data8), .sram_addr(sa8), .sram_oe_n(oe_n8), .sram_data(sd8));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read16(input logic [31:0] a, output int n);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1;
    n = 0;
    while (stall) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic read8(input logic [31:0] a, output int n);
    @(negedge clk);
    rd8 = 1'b1; addr8 = a;
    #1;
    n = 0;
    while (stall8) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  localparam int NV = 8;
  localparam logic [31:0] T_ADDR [NV] = '{
    32'h0000_0420,   // R4 R6 R5: cold miss, slow-region timing not used
    32'h0000_042C,   // R1: word 3 of the same line hits
    32'h07E0_0424,   // R2: bits 26:21 set, aliases line 0x42
    32'h0000_1420,   // R9: same index, other tag
    32'h0000_0420,   // R9: evicted address misses again
    32'h8000_0830,   // R6: region with WS_HI
    32'h8000_0834,   // R1: hit in the slow region line
    32'h0000_0FF0    // R1: last line index
  };
  localparam logic [31:0] T_SRC [NV] = '{
    32'h0000_0420, 32'h0000_042C, 32'h0000_0424, 32'h0000_1420,
    32'h0000_0420, 32'h8000_0830, 32'h8000_0834, 32'h0000_0FF0
  };
  localparam int T_STALL [NV] = '{25, 0, 0, 25, 25, 33, 0, 25};

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rd = 1'b0; rd8 = 1'b0; addr = '0; addr8 = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R3 stall in reset", 32'(stall), 32'd1);
    check("R10 oe_n in reset", 32'(oe_n), 32'd1);
    @(negedge clk);
    rst = 1'b0;
    rd = 1'b1; addr = 32'h0000_0420;
    repeat (100) @(negedge clk);
    #1;
    check("R3 stall during sweep", 32'(stall), 32'd1);
    check("R10 oe_n during sweep", 32'(oe_n), 32'd1);
    rd = 1'b0;
    repeat (200) @(negedge clk);
    #1;
    check("R10 oe_n idle", 32'(oe_n), 32'd1);

    for (int i = 0; i < NV; i++) begin
      read16(T_ADDR[i], n);
      check($sformatf("table row %0d stall cycles", i), 32'(n), 32'(T_STALL[i]));
      check($sformatf("table row %0d data", i), data, exp16(T_SRC[i]));
    end

    read16(32'h0000_0420, n);
    check("R5 high half from even address", 32'(data[31:16]), 32'(f16(24'h000210)));
    check("R5 low half from odd address", 32'(data[15:0]), 32'(f16(24'h000211)));

    @(negedge clk);
    rd = 1'b1; addr = 32'h0000_2530;
    #1;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      #1;
      check("R4 R6 R7 refill address", 32'(sa), 32'h1298 + 32'((k - 1) / 3));
      check("R10 oe_n during access", 32'(oe_n), 32'd0);
    end
    @(negedge clk);
    #1;
    check("R4 stall drops after line", 32'(stall), 32'd0);
    check("R10 oe_n after refill", 32'(oe_n), 32'd1);
    check("R4 refilled word", data, exp16(32'h0000_2530));

    @(negedge clk);
    rd = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (300) @(negedge clk);
    read16(32'h0000_2530, n);
    check("R3 line invalid after reset", 32'(n), 32'd25);
    check("R3 data after refetch", data, exp16(32'h0000_2530));

    read8(32'h0000_0420, n);
    check("R8 R7 byte bus miss stall", 32'(n), 32'd17);
    check("R8 byte order", data8, exp8(32'h0000_0420));
    read8(32'h0000_0424, n);
    check("R8 byte bus hit stall", 32'(n), 32'd0);
    check("R8 byte bus word 1", data8, exp8(32'h0000_0424));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule